// File: doc/BRIEF.md
# Mixed-Width Synchronous FIFO

This block is a single-clock FIFO built on a 4,608-bit dual-port storage array. The write side and the read side each pick a shape (word width and depth) on their own. Words go in at the write width and come out at the read width, and the block splits or assembles words as needed. The shape codes are 0 for 1 bit × 4096, 1 for 2 × 2048, 2 for 4 × 1024, 3 for 9 × 512 and 4 for 18 × 256.

Counters inside the block produce the write and read addresses. The fill level is tracked in units of the narrower of the two widths. The block drives four registered flags: Empty, Full, and Almost Empty and Almost Full, whose thresholds come from input pins. Shapes are meant to be set while reset is held and then left alone.

The 9-bit and 18-bit shapes use all nine bits of every storage row. The 1-, 2- and 4-bit shapes use eight bits of every row, so their capacity is 4,096 bits. The two groups cannot be mixed, and a mixed setting is reported as a configuration error.

Top module: `mixed_width_fifo`

## Requirements
- R1: A synchronous reset empties the FIFO and zeroes `rd_data`. On the edge where reset is sampled, `empty` and `almost_empty` go to 1 and `full` and `almost_full` go to 0.
- R2: When both ports use the same shape, words are read back in the order they were written and are unchanged.
- R3: When narrow writes feed a wider read, the first narrow write fills the least significant slice of the word that is read.
- R4: When a wide word is read through a narrower port, its least significant slice comes out first. Read-data bits above the read width are 0.
- R5: Let C be the capacity: 4,096 bits for shapes 0–2 and 4,608 bits for shapes 3–4. `full` is 1 exactly when fewer than one write word of room remains. `empty` is 1 exactly when less than one read word is stored. Both are updated on the edge that changes the contents.
- R6: A write while `full` and a read while `empty` are ignored. The stored data, the data order and `rd_data` are left as they were.
- R7: `almost_empty` is 1 when the fill level, counted in units of the narrower port width, is at or below `ae_level`. It is registered and updated on the same edge as the pointers.
- R8: `almost_full` is 1 when that same fill level is at or above `af_level`. It is registered in the same way.
- R9: `cfg_error` is 1 when one port uses shape 3 or 4 and the other uses shape 0, 1 or 2, or when either shape code is above 4. While it is 1, writes and reads are ignored.
- R10: `rd_data` is registered. It changes only on the edge after an accepted read and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_shape | input | 3 | Write-side shape code (0..4) |
| rd_shape | input | 3 | Read-side shape code (0..4) |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write word, LSB-aligned |
| rd_en | input | 1 | Read request |
| rd_data | output | 18 | Read word, LSB-aligned, registered |
| ae_level | input | 13 | Almost-empty threshold in narrow-port units |
| af_level | input | 13 | Almost-full threshold in narrow-port units |
| empty | output | 1 | Less than one read word stored |
| full | output | 1 | No room for one write word |
| almost_empty | output | 1 | Fill level at or below `ae_level` |
| almost_full | output | 1 | Fill level at or above `af_level` |
| cfg_error | output | 1 | Invalid shape combination |

## Verification
The hardest case to reach from the ports is the full boundary with the narrowest port settings. With a 1-bit write port, 4,096 separate writes are needed before `full` rises and a rejected write can be tried. The bench therefore sweeps every valid pair of shapes. For each pair it fills the array until the model says there is no room, tries one more write, drains the array completely, tries a read on the empty array, and then runs a mixed read/write phase. A bit-serial queue model predicts every flag and every read word, including how the pointers wrap after the array has been filled and drained.

// File: rtl/mixed_width_fifo.sv
module mixed_width_fifo #(
  parameter int ROWS = 512,
  parameter int ROWW = 9,
  parameter int LW   = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        wr_shape,
  input  logic [2:0]        rd_shape,
  input  logic              wr_en,
  input  logic [2*ROWW-1:0] wr_data,
  input  logic              rd_en,
  output logic [2*ROWW-1:0] rd_data,
  input  logic [LW-1:0]     ae_level,
  input  logic [LW-1:0]     af_level,
  output logic              empty,
  output logic              full,
  output logic              almost_empty,
  output logic              almost_full,
  output logic              cfg_error
);
  localparam int AW = $clog2(ROWS);
  localparam logic [LW-1:0] CAP_NARROW = LW'(ROWS * 8);
  localparam logic [LW-1:0] CAP_WIDE   = LW'(ROWS);

  logic [ROWW-1:0] mem [ROWS];
  logic [LW-1:0] wptr, rptr, level, level_n, wstep, rstep, cap, lvl_u;
  logic [2*ROWW-1:0] rword;
  logic wide_w, wide_r, wide, do_wr, do_rd;
  logic [1:0] sh;
  logic [AW-1:0] wrow, rrow;
  logic [2:0] wbit, rbit;

  function automatic logic [LW-1:0] step_of(input logic [2:0] s);
    if (s == 3'd4) return LW'(2);
    if (s == 3'd3) return LW'(1);
    return LW'(1) << s[1:0];
  endfunction

  function automatic logic [LW-1:0] adv(input logic [LW-1:0] p, input logic [LW-1:0] st,
                                        input logic [LW-1:0] c);
    logic [LW-1:0] n;
    n = p + st;
    return (n >= c) ? '0 : n;
  endfunction

  assign wide_w    = (wr_shape == 3'd3) || (wr_shape == 3'd4);
  assign wide_r    = (rd_shape == 3'd3) || (rd_shape == 3'd4);
  assign wide      = wide_w;
  assign cfg_error = (wr_shape > 3'd4) || (rd_shape > 3'd4) || (wide_w != wide_r);
  assign wstep     = step_of(wr_shape);
  assign rstep     = step_of(rd_shape);
  assign cap       = wide ? CAP_WIDE : CAP_NARROW;
  assign sh        = wide ? {1'b0, (wr_shape == 3'd4) && (rd_shape == 3'd4)}
                          : ((wr_shape[1:0] < rd_shape[1:0]) ? wr_shape[1:0] : rd_shape[1:0]);

  assign do_wr = wr_en && !full && !cfg_error;
  assign do_rd = rd_en && !empty && !cfg_error;

  assign wrow = wide ? wptr[AW-1:0] : wptr[AW+2:3];
  assign rrow = wide ? rptr[AW-1:0] : rptr[AW+2:3];
  assign wbit = wptr[2:0];
  assign rbit = rptr[2:0];

  assign level_n = level + (do_wr ? wstep : '0) - (do_rd ? rstep : '0);
  assign lvl_u   = level_n >> sh;

  always_ff @(posedge clk) begin
    if (do_wr) begin
      if (wide) begin
        mem[wrow] <= wr_data[ROWW-1:0];
        if (wr_shape == 3'd4) mem[AW'(wrow + 1'b1)] <= wr_data[2*ROWW-1:ROWW];
      end else begin
        for (int i = 0; i < 4; i++)
          if (i < int'(wstep)) mem[wrow][3'(wbit + 3'(i))] <= wr_data[i];
      end
    end
  end

  always_comb begin
    rword = '0;
    if (wide) begin
      rword[ROWW-1:0] = mem[rrow];
      if (rd_shape == 3'd4) rword[2*ROWW-1:ROWW] = mem[AW'(rrow + 1'b1)];
    end else begin
      for (int i = 0; i < 4; i++)
        if (i < int'(rstep)) rword[i] = mem[rrow][3'(rbit + 3'(i))];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      level <= '0;
      rd_data <= '0;
      empty <= 1'b1;
      almost_empty <= 1'b1;
      full <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      if (do_wr) wptr <= adv(wptr, wstep, cap);
      if (do_rd) begin
        rptr <= adv(rptr, rstep, cap);
        rd_data <= rword;
      end
      level <= level_n;
      empty <= level_n < rstep;
      full <= (level_n + wstep) > cap;
      almost_empty <= lvl_u <= ae_level;
      almost_full <= lvl_u >= af_level;
    end
  end

  AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (empty && almost_empty && !full && !almost_full && rd_data == '0)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level <= cap); // R5
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !cfg_error |-> !(empty && full)); // R5
  AST_FULL_WRITE_HELD: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en) |=> $stable(wptr)); // R6
  AST_EMPTY_READ_HELD: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en) |=> $stable(rptr)); // R6
  AST_CFG_FREEZE: assert property (@(posedge clk) disable iff (rst)
    cfg_error |=> $stable(level)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R10
endmodule

// File: tb/tb_mixed_width_fifo.sv
module tb_mixed_width_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] wsh = 3'd0, rsh = 3'd0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [17:0] wr_data = '0;
  logic [17:0] rd_data;
  logic [12:0] ae_th = '0, af_th = '0;
  logic empty, full, almost_empty, almost_full, cfg_error;

  int total = 0, bad = 0;
  bit finished = 0;
  bit q[$];
  logic [17:0] last_rd = '0;

  always #2.5 clk = ~clk;

  mixed_width_fifo dut (
    .clk(clk), .rst(rst), .wr_shape(wsh), .rd_shape(rsh),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ae_level(ae_th), .af_level(af_th), .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full), .cfg_error(cfg_error));

  function automatic int wof(input int code);
    if (code == 3) return 9;
    if (code == 4) return 18;
    return 1 << code;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      if (bad <= 20) $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_flags();
    int ww = wof(int'(wsh)), rw = wof(int'(rsh));
    int capb = (wsh >= 3) ? 4608 : 4096;
    int minw = (ww < rw) ? ww : rw;
    int lvl = q.size() / minw;
    chk(empty == (q.size() < rw), "R5 empty", 32'(empty), 32'(q.size() < rw));
    chk(full == (q.size() + ww > capb), "R5 full", 32'(full), 32'(q.size() + ww > capb));
    chk(almost_empty == (lvl <= int'(ae_th)), "R7 almost_empty", 32'(almost_empty), 32'(lvl <= int'(ae_th)));
    chk(almost_full == (lvl >= int'(af_th)), "R8 almost_full", 32'(almost_full), 32'(lvl >= int'(af_th)));
    chk(cfg_error == 1'b0, "R9 cfg_error", 32'(cfg_error), 0);
  endtask

  task automatic step(input bit we, input logic [17:0] wd, input bit re);
    int ww = wof(int'(wsh)), rw = wof(int'(rsh));
    int capb = (wsh >= 3) ? 4608 : 4096;
    bit dw, dr;
    logic [17:0] e;
    string tag;
    dw = we && (q.size() + ww <= capb);
    dr = re && (q.size() >= rw);
    wr_en = we; wr_data = wd; rd_en = re;
    if (dr) begin
      e = '0;
      for (int i = 0; i < rw; i++) e[i] = q.pop_front();
      last_rd = e;
    end
    if (dw) for (int i = 0; i < ww; i++) q.push_back(wd[i]);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_flags();
    tag = (ww == rw) ? "R2 data" : (ww < rw) ? "R3 data" : "R4 data";
    if (dr) chk(rd_data == last_rd, tag, 32'(rd_data), 32'(last_rd));
    else chk(rd_data == last_rd, "R10 hold", 32'(rd_data), 32'(last_rd));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(empty && almost_empty && !full && !almost_full, "R1 flags",
        {empty, almost_empty, full, almost_full}, 32'b1100);
    chk(rd_data == '0, "R1 rd_data", 32'(rd_data), 0);
    q.delete();
    last_rd = '0;
    rst = 1'b0;
  endtask

  task automatic run_cfg(input int wc, input int rc, input int seed);
    int ww = wof(wc), rw = wof(rc);
    int capb = (wc >= 3) ? 4608 : 4096;
    int minw = (ww < rw) ? ww : rw;
    int capu = capb / minw;
    int k = 0;
    wsh = 3'(wc); rsh = 3'(rc);
    ae_th = 13'(capu / 4);
    af_th = 13'(capu * 3 / 4);
    do_reset();
    while (q.size() + ww <= capb) begin
      step(1'b1, 18'(k * 37 + seed * 11 + 5) ^ 18'(k << 7), 1'b0);
      k++;
    end
    chk(k == capb / ww, "R5 write count", 32'(k), 32'(capb / ww));
    chk(full == 1'b1, "R5 full at capacity", 32'(full), 1);
    step(1'b1, 18'h3ffff, 1'b0);
    while (q.size() >= rw) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    chk(empty == 1'b1, "R6 read while empty", 32'(empty), 1);
    for (int j = 0; j < 300; j++)
      step((j % 3) != 0, 18'(j * 91 + seed), ((j / 2) % 3) != 1);
    while (q.size() >= rw) step(1'b0, '0, 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int w = 0; w < 3; w++)
      for (int r = 0; r < 3; r++)
        run_cfg(w, r, w * 3 + r);
    for (int w = 3; w < 5; w++)
      for (int r = 3; r < 5; r++)
        run_cfg(w, r, w * 5 + r);

    wsh = 3'd3; rsh = 3'd1;
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    chk(cfg_error == 1'b1, "R9 mixed groups", 32'(cfg_error), 1);
    wr_en = 1'b1; wr_data = 18'h1ff;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk(empty == 1'b1, "R9 write ignored", 32'(empty), 1);
    wsh = 3'd1; rsh = 3'd4;
    @(negedge clk);
    chk(cfg_error == 1'b1, "R9 mixed groups reversed", 32'(cfg_error), 1);
    wsh = 3'd0; rsh = 3'd5;
    @(negedge clk);
    chk(cfg_error == 1'b1, "R9 bad code", 32'(cfg_error), 1);
    rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == '0, "R9 read ignored", 32'(rd_data), 0);
    wsh = 3'd2; rsh = 3'd2;
    @(negedge clk);
    chk(cfg_error == 1'b0, "R9 valid clears", 32'(cfg_error), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule